// File: doc/BRIEF.md
# Real-time clock register file and interrupt unit

This block is the byte-addressed register file of a real-time clock. It decodes addresses 0x00 to 0x0D and holds ten time and alarm bytes, the divider and rate byte (status A), the control and enable byte (status B), the interrupt flag byte (status C) and the power status byte (status D). The seconds/minutes/hours counter and the divider chain live outside the block. They receive the configuration fields through dedicated outputs and return update-in-progress, power-good and three event pulses: periodic, alarm and update-ended.

Software reaches the registers through a single-cycle strobe bus. Writes take effect at the clock edge. Read data is combinational from the current state. The external counter writes time bytes through its own port, and that port is blocked while the set bit is 1. Events are latched into sticky flags. The interrupt output is raised when a latched flag has its enable bit set. Reading status C returns the flags and clears them.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, status A reads 0x26 (bit 7 follows the update input), status B reads 0x02, status C reads 0x00 and every time byte reads 0x00.
- R2: Addresses 0x00 to 0x09 are read/write bytes. Addresses 0x0E and 0x0F read as 0x00 and ignore writes.
- R3: A counter-port write updates the addressed time byte only while status B bit 7 (set) is 0. When the bus and the counter write the same byte in the same cycle, the bus value is kept.
- R4: Status A bit 7 always reads the update-in-progress input, and writes to bit 7 are dropped. Bits 6:5 (divider), bit 4 (bank) and bits 3:0 (rate) are read/write and drive the div_sel_o, bank_o and rate_o outputs.
- R5: Status B is fully read/write and is presented on ctrl_b_o. Its fields are: bit 7 set, bit 6 periodic enable, bit 5 alarm enable, bit 4 update-ended enable, bit 3 square-wave enable, bit 2 binary mode, bit 1 24-hour mode, bit 0 daylight-saving enable.
- R6: A periodic, alarm or update-ended event pulse sets status C bit 6, 5 or 4 respectively, whatever the enable bits are. The flag stays set until status C is read.
- R7: Status C bit 7 and the irq output are 1 exactly when some flag in bits 6:4 has its matching enable in status B bits 6:4 set. Status C bits 3:0 read as 0.
- R8: A read of status C returns the flags as they were before the read, then clears bits 7:4. An event in the same cycle as the read is kept for the next read.
- R9: Status D reads pwr_good in bit 7 and 0 in bits 6:0. Writes to status C and status D have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (a read of status C clears it) |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data for addr |
| cnt_we | input | 1 | Counter write strobe for a time byte |
| cnt_idx | input | ADDR_W | Time byte index for the counter write |
| cnt_data | input | 8 | Counter write data |
| uip_in | input | 1 | Update-in-progress from the counter |
| pwr_good | input | 1 | Register contents valid |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| irq | output | 1 | Combined interrupt request |
| div_sel_o | output | 2 | Divider select field |
| bank_o | output | 1 | Bank control field |
| rate_o | output | 4 | Rate select field |
| ctrl_b_o | output | 8 | Status B contents |
| time_o | output | NUM_TIME_BYTES*8 | Time and alarm bytes, byte 0 in the low bits |

## Verification
The bench builds the block with its defaults: ten time bytes and a four-bit address. With these values the two unmapped addresses 0x0E and 0x0F can be reached, so their read-as-zero behaviour is exercised next to the mapped status bytes. The vector table covers all four status addresses and the first and last time bytes. Directed sequences cover an event that coincides with a status C read, an enable that is turned on after its flag was already latched, and a bus write that collides with a counter write.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
    localparam int BYTE_W = 8;

    localparam logic [3:0] ADR_STA = 4'hA;
    localparam logic [3:0] ADR_STB = 4'hB;
    localparam logic [3:0] ADR_STC = 4'hC;
    localparam logic [3:0] ADR_STD = 4'hD;

    localparam int B_SET = 7;

    // Event / flag group, ordered as status C bits 6:4 and status B bits 6:4
    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } evt_t;
endpackage

// File: rtl/rtc_time_bank.sv
module rtc_time_bank #(
    parameter int NUM = 10,
    parameter int AW  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_idx,
    input  logic [7:0]           bus_data,
    input  logic                 cnt_we,
    input  logic [AW-1:0]        cnt_idx,
    input  logic [7:0]           cnt_data,
    input  logic                 freeze,
    output logic [NUM-1:0][7:0]  bytes_o
);
    typedef struct packed {
        logic [NUM-1:0][7:0] b;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM; i++) begin
            if (!freeze && cnt_we && cnt_idx == AW'(i))
                bank_d.b[i] = cnt_data;
            if (bus_we && bus_idx == AW'(i))
                bank_d.b[i] = bus_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bytes_o = bank_q.b;

    // R3: counter writes are blocked while the set bit holds the clock
    p_set_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && cnt_we && !bus_we) |=> $stable(bytes_o));
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt,
    input  evt_t en,
    input  logic rd_clr,
    output evt_t flags_o,
    output logic pending_o
);
    typedef struct packed {
        evt_t f;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.f = (rd_clr ? evt_t'('0) : st_q.f) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o   = st_q.f;
    assign pending_o = |(3'(st_q.f) & 3'(en));

    // R6: every event pulse is latched the following cycle
    p_evt_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|3'(evt)) |=> ((3'(flags_o) & 3'($past(evt))) == 3'($past(evt))));

    // R6: flags are sticky until a clearing read
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((3'(flags_o) & 3'($past(flags_o))) == 3'($past(flags_o))));

    // R8: a read with no concurrent event empties the flags
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && 3'(evt) == 3'b0) |=> (3'(flags_o) == 3'b0));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_regs_pkg::*;
#(
    parameter int          ADDR_W         = 4,
    parameter int          NUM_TIME_BYTES = 10,
    parameter logic [7:0]  RESET_A        = 8'h26,
    parameter logic [7:0]  RESET_B        = 8'h02
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    input  logic                        cnt_we,
    input  logic [ADDR_W-1:0]           cnt_idx,
    input  logic [7:0]                  cnt_data,
    input  logic                        uip_in,
    input  logic                        pwr_good,
    input  logic                        evt_periodic,
    input  logic                        evt_alarm,
    input  logic                        evt_update,
    output logic                        irq,
    output logic [1:0]                  div_sel_o,
    output logic                        bank_o,
    output logic [3:0]                  rate_o,
    output logic [7:0]                  ctrl_b_o,
    output logic [NUM_TIME_BYTES*8-1:0] time_o
);
    localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(ADR_STA);
    localparam logic [ADDR_W-1:0] A_STB = ADDR_W'(ADR_STB);
    localparam logic [ADDR_W-1:0] A_STC = ADDR_W'(ADR_STC);
    localparam logic [ADDR_W-1:0] A_STD = ADDR_W'(ADR_STD);

    typedef struct packed {
        logic [6:0]        a;
        logic [BYTE_W-1:0] b;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_TIME_BYTES-1:0][7:0] tbytes;
    evt_t  evt, en, flags;
    logic  pending;
    logic  rd_clr;
    logic  bus_time_we;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en && addr == A_STA) ctl_d.a = wdata[6:0];
        if (wr_en && addr == A_STB) ctl_d.b = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{a: RESET_A[6:0], b: RESET_B};
        else        ctl_q <= ctl_d;
    end

    assign bus_time_we = wr_en && (32'(addr) < NUM_TIME_BYTES);
    assign rd_clr      = rd_en && addr == A_STC;
    assign evt         = '{pf: evt_periodic, af: evt_alarm, uf: evt_update};
    assign en          = evt_t'(ctl_q.b[6:4]);

    rtc_time_bank #(.NUM(NUM_TIME_BYTES), .AW(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_time_we),
        .bus_idx  (addr),
        .bus_data (wdata),
        .cnt_we   (cnt_we),
        .cnt_idx  (cnt_idx),
        .cnt_data (cnt_data),
        .freeze   (ctl_q.b[B_SET]),
        .bytes_o  (tbytes)
    );

    rtc_irq_unit u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .en        (en),
        .rd_clr    (rd_clr),
        .flags_o   (flags),
        .pending_o (pending)
    );

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_TIME_BYTES; i++)
            if (addr == ADDR_W'(i)) rdata = tbytes[i];
        if (addr == A_STA) rdata = {uip_in, ctl_q.a};
        if (addr == A_STB) rdata = ctl_q.b;
        if (addr == A_STC) rdata = {pending, 3'(flags), 4'b0000};
        if (addr == A_STD) rdata = {pwr_good, 7'b0};
    end

    assign irq       = pending;
    assign div_sel_o = ctl_q.a[6:5];
    assign bank_o    = ctl_q.a[4];
    assign rate_o    = ctl_q.a[3:0];
    assign ctrl_b_o  = ctl_q.b;
    assign time_o    = tbytes;

    // R5: a bus write to status B is visible on ctrl_b_o next cycle
    p_b_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STB) |=> (ctrl_b_o == $past(wdata)));

    // R7: the request never rises without some enable bit set
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl_b_o[6:4] != 3'b000));

    // R4: writes elsewhere leave the status A fields unchanged
    p_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_STA) |=> $stable({div_sel_o, bank_o, rate_o}));
endmodule

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        cnt_we = 1'b0;
    logic [3:0]  cnt_idx = '0;
    logic [7:0]  cnt_data = '0;
    logic        uip_in = 1'b0, pwr_good = 1'b1;
    logic        evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
    logic        irq;
    logic [1:0]  div_sel_o;
    logic        bank_o;
    logic [3:0]  rate_o;
    logic [7:0]  ctrl_b_o;
    logic [79:0] time_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_regfile u_rtc_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_we(cnt_we), .cnt_idx(cnt_idx),
        .cnt_data(cnt_data), .uip_in(uip_in), .pwr_good(pwr_good),
        .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
        .irq(irq), .div_sel_o(div_sel_o), .bank_o(bank_o), .rate_o(rate_o),
        .ctrl_b_o(ctrl_b_o), .time_o(time_o)
    );

    typedef struct packed {
        logic       wr;
        logic [3:0] a;
        logic [7:0] d;   // write data, or expected read data
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'h0, 8'h59}, '{1'b1, 4'h9, 8'h99},
        '{1'b0, 4'h0, 8'h59}, '{1'b0, 4'h9, 8'h99},
        '{1'b1, 4'hA, 8'hFF}, '{1'b0, 4'hA, 8'h7F},
        '{1'b1, 4'hB, 8'h5A}, '{1'b0, 4'hB, 8'h5A},
        '{1'b1, 4'hC, 8'hFF}, '{1'b0, 4'hC, 8'h00},
        '{1'b1, 4'hD, 8'h00}, '{1'b0, 4'hD, 8'h80},
        '{1'b1, 4'hE, 8'h77}, '{1'b0, 4'hE, 8'h00}
    };

    function automatic string tag_of(input logic [3:0] a);
        if (a < 4'hA)       return "R2";
        else if (a == 4'hA) return "R4";
        else if (a == 4'hB) return "R5";
        else if (a >= 4'hE) return "R2";
        else                return "R9";
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic cnt_write(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk);
        cnt_we = 1'b1; cnt_idx = i; cnt_data = d;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic pulse(input logic p, input logic al, input logic u);
        @(negedge clk);
        evt_periodic = p; evt_alarm = al; evt_update = u;
        @(negedge clk);
        evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(4'hA, r); check("R1", r, 8'h26);
        bus_read(4'hB, r); check("R1", r, 8'h02);
        bus_read(4'hC, r); check("R1", r, 8'h00);
        bus_read(4'h3, r); check("R1", r, 8'h00);
        check("R1", {7'b0, irq}, 8'h00);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) bus_write(VEC[k].a, VEC[k].d);
            else begin
                bus_read(VEC[k].a, r);
                check(tag_of(VEC[k].a), r, VEC[k].d);
            end
        end

        // R4 field outputs and read-only bit 7
        check("R4", {1'b0, div_sel_o, bank_o, rate_o}, 8'h7F);
        uip_in = 1'b1;
        bus_read(4'hA, r); check("R4", r, 8'hFF);
        uip_in = 1'b0;

        // R3 counter port
        bus_write(4'hB, 8'h02);
        cnt_write(4'h0, 8'h12);
        bus_read(4'h0, r); check("R3", r, 8'h12);
        bus_write(4'hB, 8'h82);
        cnt_write(4'h0, 8'h34);
        bus_read(4'h0, r); check("R3", r, 8'h12);
        check("R5", ctrl_b_o, 8'h82);
        bus_write(4'hB, 8'h02);
        @(negedge clk);
        cnt_we = 1'b1; cnt_idx = 4'h1; cnt_data = 8'h66;
        wr_en = 1'b1; addr = 4'h1; wdata = 8'h55;
        @(negedge clk);
        cnt_we = 1'b0; wr_en = 1'b0;
        bus_read(4'h1, r); check("R3", r, 8'h55);
        check("R3", time_o[15:8], 8'h55);

        // R6 / R7 flags without enable
        bus_read(4'hC, r);
        pulse(1'b1, 1'b0, 1'b0);
        check("R7", {7'b0, irq}, 8'h00);
        bus_read(4'hC, r); check("R6", r, 8'h40);
        bus_read(4'hC, r); check("R8", r, 8'h00);

        // R7 enabled periodic, R8 event concurrent with read
        bus_write(4'hB, 8'h42);
        pulse(1'b1, 1'b0, 1'b0);
        check("R7", {7'b0, irq}, 8'h01);
        @(negedge clk);
        rd_en = 1'b1; addr = 4'hC; evt_alarm = 1'b1;
        #2 r = rdata;
        @(negedge clk);
        rd_en = 1'b0; evt_alarm = 1'b0;
        check("R8", r, 8'hC0);
        check("R7", {7'b0, irq}, 8'h00);
        bus_write(4'hB, 8'h22);
        check("R7", {7'b0, irq}, 8'h01);
        bus_read(4'hC, r); check("R8", r, 8'hA0);

        // R6 update-ended flag
        bus_write(4'hB, 8'h12);
        pulse(1'b0, 1'b0, 1'b1);
        bus_read(4'hC, r); check("R6", r, 8'h90);

        // R9 power status
        pwr_good = 1'b0;
        bus_read(4'hD, r); check("R9", r, 8'h00);

        finish_run();
    end
endmodule